// File: doc/BRIEF.md
# Memory Sleep and Wake Controller

This block moves a nonvolatile memory array between normal read operation and a low-power sleep state. Two sources can ask for sleep: a software control bit, and an external global sleep line that can be masked by a disable bit. The block waits until the access logic reports that the array is idle before it starts. It then switches the analog blocks off in a fixed order. It wakes the array on a falling edge of whichever source put it to sleep, and switches the analog blocks back on in the reverse order.

Each analog step is a handshake. An enable output changes level, and the matching done input must pulse before the sequence moves on. If a done pulse does not arrive in time, a step counter sets a sticky error flag. Outside read mode the block reports busy. Any access made while the block is busy is answered with a retry strobe.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: With `array_idle` high in read mode, setting `sw_sleep` starts sleep entry: `sense_en` falls at the next clock edge.
- R2: `ext_sleep` passes through a two-flop synchroniser. It starts sleep entry only while `ext_sleep_dis` is low. When `ext_sleep_dis` is high, the external line alone never leaves read mode.
- R3: While `array_idle` is low, read mode is kept regardless of any sleep request.
- R4: Entry is strictly ordered: `sense_en` falls, then `sense_done` is awaited. Next `vreg_en` falls, then `vreg_done` is awaited. Last `osc_en` falls, then `osc_done` is awaited. Each level changes one edge after the previous step's done pulse.
- R5: `sleep_mode` is 1 exactly while the sleep state is held. In that state all three enables are 0.
- R6: In sleep, only a 1-to-0 transition of the source that caused the sleep starts wake-up. For `ext_sleep`, the edge is taken from the synchronised value. A transition of the other source is ignored.
- R7: Wake is strictly ordered: `osc_en` rises, then `osc_done` is awaited. Next `vreg_en` rises, then `vreg_done` is awaited. Last `sense_en` rises, then `sense_done` is awaited, and read mode returns.
- R8: A falling edge of the sleep source that occurs during ramp-down is discarded. The array still reaches sleep and stays there.
- R9: `busy` is 1 in every state other than read mode, including ramp-down, sleep and wake-up.
- R10: `retry` equals `acc_req` while `busy` is 1, and is 0 in read mode.
- R11: If a step waits `STEP_TMO` cycles without its done pulse, `ramp_err` sets and stays 1 until reset. The sequence still advances when the done pulse arrives later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_sleep | input | 1 | Software sleep control bit |
| ext_sleep | input | 1 | Asynchronous external global sleep request |
| ext_sleep_dis | input | 1 | Masks the external sleep request when 1 |
| array_idle | input | 1 | No access pending or active |
| acc_req | input | 1 | Read or write access strobe |
| sense_done | input | 1 | Pulse: sense amplifier step finished |
| vreg_done | input | 1 | Pulse: voltage ramp step finished |
| osc_done | input | 1 | Pulse: oscillator step finished |
| sense_en | output | 1 | Sense amplifier enable |
| vreg_en | output | 1 | Voltage regulator enable |
| osc_en | output | 1 | Array oscillator enable |
| sleep_mode | output | 1 | Sleep state status |
| busy | output | 1 | Array unavailable |
| retry | output | 1 | Access answered with retry |
| ramp_err | output | 1 | Sticky step timeout error |

## Verification
The bench builds the block with `STEP_TMO` set to 8, and its done responder answers after two cycles. A full sleep and wake round trip therefore takes only a few dozen cycles, so every source, mask and ignored-edge case fits into one short run. Holding back one done pulse for more than eight cycles brings the timeout path within reach. The run also shows that the error stays set while the sequence goes on to complete.

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl #(
  parameter int STEP_TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_sleep,
  input  logic ext_sleep,
  input  logic ext_sleep_dis,
  input  logic array_idle,
  input  logic acc_req,
  input  logic sense_done,
  input  logic vreg_done,
  input  logic osc_done,
  output logic sense_en,
  output logic vreg_en,
  output logic osc_en,
  output logic sleep_mode,
  output logic busy,
  output logic retry,
  output logic ramp_err
);
  localparam int TW = $clog2(STEP_TMO + 1);

  typedef enum logic [2:0] {
    S_READ, S_SA_OFF, S_VR_DN, S_OSC_OFF, S_SLEEP, S_OSC_ON, S_VR_UP, S_SA_ON
  } state_t;

  state_t st, st_nxt;
  logic ext_s1, ext_s2, ext_s3, sw_q, src_sw;
  logic [TW-1:0] tcnt;
  logic ramp, step_done, ext_fall, sw_fall, go_sleep;

  assign ext_fall = ext_s3 & ~ext_s2;
  assign sw_fall  = sw_q & ~sw_sleep;
  assign go_sleep = array_idle & (sw_sleep | (ext_s2 & ~ext_sleep_dis));
  assign ramp     = (st != S_READ) && (st != S_SLEEP);

  always_comb begin
    case (st)
      S_SA_OFF, S_SA_ON:  step_done = sense_done;
      S_VR_DN, S_VR_UP:   step_done = vreg_done;
      S_OSC_OFF, S_OSC_ON: step_done = osc_done;
      default:            step_done = 1'b0;
    endcase
  end

  always_comb begin
    st_nxt = st;
    case (st)
      S_READ:    if (go_sleep) st_nxt = S_SA_OFF;
      S_SA_OFF:  if (step_done) st_nxt = S_VR_DN;
      S_VR_DN:   if (step_done) st_nxt = S_OSC_OFF;
      S_OSC_OFF: if (step_done) st_nxt = S_SLEEP;
      S_SLEEP:   if (src_sw ? sw_fall : ext_fall) st_nxt = S_OSC_ON;
      S_OSC_ON:  if (step_done) st_nxt = S_VR_UP;
      S_VR_UP:   if (step_done) st_nxt = S_SA_ON;
      S_SA_ON:   if (step_done) st_nxt = S_READ;
      default:   st_nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_READ;
      ext_s1   <= 1'b0;
      ext_s2   <= 1'b0;
      ext_s3   <= 1'b0;
      sw_q     <= 1'b0;
      src_sw   <= 1'b0;
      tcnt     <= '0;
      ramp_err <= 1'b0;
    end else begin
      ext_s1 <= ext_sleep;
      ext_s2 <= ext_s1;
      ext_s3 <= ext_s2;
      sw_q   <= sw_sleep;
      st     <= st_nxt;
      if (st == S_READ && go_sleep) src_sw <= sw_sleep;
      if (!ramp || step_done) tcnt <= '0;
      else if (tcnt != TW'(STEP_TMO)) tcnt <= tcnt + 1'b1;
      if (ramp && !step_done && tcnt == TW'(STEP_TMO - 1)) ramp_err <= 1'b1;
    end
  end

  assign sense_en   = (st == S_READ) || (st == S_SA_ON);
  assign vreg_en    = (st == S_READ) || (st == S_SA_OFF) || (st == S_VR_UP) || (st == S_SA_ON);
  assign osc_en     = (st != S_OSC_OFF) && (st != S_SLEEP);
  assign sleep_mode = (st == S_SLEEP);
  assign busy       = (st != S_READ);
  assign retry      = acc_req & busy;

  // R3
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && !array_idle) |=> st == S_READ);
  // R4
  vreg_down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vreg_en) |-> !sense_en);
  // R4
  osc_down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> !sense_en && !vreg_en);
  // R5
  sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |-> !sense_en && !vreg_en && !osc_en);
  // R7
  vreg_up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vreg_en) |-> osc_en);
  // R7
  sense_up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_en) |-> osc_en && vreg_en);
  // R9
  ready_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sense_en && vreg_en && osc_en);
  // R10
  sleep_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && sleep_mode) |-> retry);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_err |=> ramp_err);
endmodule

// File: tb/mem_sleep_ctrl_bench.sv
module mem_sleep_ctrl_bench;
  localparam int TMO = 8;
  localparam int DLY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_sleep = 0, ext_sleep = 0, ext_sleep_dis = 0, array_idle = 1, acc_req = 0;
  logic sense_done = 0, vreg_done = 0, osc_done = 0;
  logic sense_en, vreg_en, osc_en, sleep_mode, busy, retry, ramp_err;

  mem_sleep_ctrl #(.STEP_TMO(TMO)) u_mem_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_sleep(sw_sleep), .ext_sleep(ext_sleep),
    .ext_sleep_dis(ext_sleep_dis), .array_idle(array_idle), .acc_req(acc_req),
    .sense_done(sense_done), .vreg_done(vreg_done), .osc_done(osc_done),
    .sense_en(sense_en), .vreg_en(vreg_en), .osc_en(osc_en),
    .sleep_mode(sleep_mode), .busy(busy), .retry(retry), .ramp_err(ramp_err));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 read, 1..3 ramp down, 4 sleep, 5..7 ramp up
  int phase = 0, k = 0;
  bit m_err = 0, m_src_sw = 0, sw_prev = 0;
  bit ext_h[3] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; k = 0; m_err = 0; m_src_sw = 0; sw_prev = 0;
      ext_h = '{0, 0, 0};
    end else begin
      bit lvl, prv, d, adv;
      lvl = ext_h[1]; prv = ext_h[2];
      d = (phase == 1 || phase == 7) ? sense_done :
          (phase == 2 || phase == 6) ? vreg_done :
          (phase == 3 || phase == 5) ? osc_done : 1'b0;
      adv = 0;
      if (phase == 0) begin
        if (array_idle && (sw_sleep || (lvl && !ext_sleep_dis))) begin
          m_src_sw = sw_sleep; adv = 1;
        end
      end else if (phase == 4) begin
        if (m_src_sw ? (sw_prev && !sw_sleep) : (prv && !lvl)) adv = 1;
      end else if (d) adv = 1;
      else begin
        if (k < TMO) k++;
        if (k == TMO) m_err = 1;
      end
      if (adv) begin phase = (phase + 1) % 8; k = 0; end
      sw_prev = sw_sleep;
      ext_h[2] = ext_h[1]; ext_h[1] = ext_h[0]; ext_h[0] = ext_sleep;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #1;
    if (rst_n && !done_run) begin
      bit e_sa, e_vr, e_osc, e_busy;
      e_sa = (phase == 0 || phase == 7);
      e_vr = (phase == 0 || phase == 1 || phase == 6 || phase == 7);
      e_osc = !(phase == 3 || phase == 4);
      e_busy = (phase != 0);
      chk(sense_en == e_sa, "R4 R7 sense_en", sense_en, e_sa);
      chk(vreg_en == e_vr, "R4 R7 vreg_en", vreg_en, e_vr);
      chk(osc_en == e_osc, "R4 R7 osc_en", osc_en, e_osc);
      chk(sleep_mode == (phase == 4), "R5 sleep_mode", sleep_mode, phase == 4);
      chk(busy == e_busy, "R9 busy", busy, e_busy);
      chk(retry == (acc_req && e_busy), "R10 retry", retry, acc_req && e_busy);
      chk(ramp_err == m_err, "R11 ramp_err", ramp_err, m_err);
    end
  end

  // analog done responder
  bit hold_sense = 0;
  bit a_sa = 1, a_vr = 1, a_osc = 1;
  int c_sa = 0, c_vr = 0, c_osc = 0;
  always @(negedge clk) begin
    sense_done <= 0; vreg_done <= 0; osc_done <= 0;
    if (rst_n) begin
      if (sense_en != a_sa) begin
        c_sa++;
        if (c_sa >= DLY && !hold_sense) begin sense_done <= 1; a_sa = sense_en; c_sa = 0; end
      end
      if (vreg_en != a_vr) begin
        c_vr++;
        if (c_vr >= DLY) begin vreg_done <= 1; a_vr = vreg_en; c_vr = 0; end
      end
      if (osc_en != a_osc) begin
        c_osc++;
        if (c_osc >= DLY) begin osc_done <= 1; a_osc = osc_en; c_osc = 0; end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_run) begin
      done_run = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(sense_en && vreg_en && osc_en && !busy && !sleep_mode && !ramp_err,
        "R9 reset state", {sense_en, vreg_en, osc_en, busy}, 4'b1110);
    rst_n = 1;
    cyc(2);
    // R3: not idle, sw request pending
    array_idle = 0; sw_sleep = 1;
    cyc(10);
    chk(!busy, "R3 deferred entry", busy, 0);
    // R1
    array_idle = 1;
    cyc(1);
    chk(!sense_en, "R1 sw entry starts", sense_en, 0);
    cyc(25);
    chk(sleep_mode, "R5 sleep reached", sleep_mode, 1);
    // R10
    acc_req = 1; cyc(1);
    chk(retry, "R10 retry in sleep", retry, 1);
    acc_req = 0;
    // R6: ext edge ignored when sw is source
    ext_sleep = 1; cyc(5); ext_sleep = 0; cyc(10);
    chk(sleep_mode, "R6 ext edge ignored", sleep_mode, 1);
    // R7 wake by sw
    sw_sleep = 0; cyc(1);
    chk(osc_en && !vreg_en, "R7 wake osc first", osc_en, 1);
    cyc(25);
    chk(!busy && sense_en, "R7 back to read", busy, 0);
    acc_req = 1; cyc(1);
    chk(!retry, "R10 no retry in read", retry, 0);
    acc_req = 0;
    // R2 masked
    ext_sleep_dis = 1; ext_sleep = 1; cyc(12);
    chk(!busy, "R2 masked ext", busy, 0);
    ext_sleep_dis = 0; cyc(1);
    chk(!sense_en, "R2 ext entry", sense_en, 0);
    cyc(25);
    chk(sleep_mode, "R2 ext sleep reached", sleep_mode, 1);
    // R6 sw edge ignored when ext is source
    sw_sleep = 1; cyc(3); sw_sleep = 0; cyc(10);
    chk(sleep_mode, "R6 sw edge ignored", sleep_mode, 1);
    ext_sleep = 0; cyc(30);
    chk(!busy, "R6 ext fall wakes", busy, 0);
    // R8 sw released during ramp-down
    sw_sleep = 1; cyc(3); sw_sleep = 0; cyc(30);
    chk(sleep_mode, "R8 early release ignored", sleep_mode, 1);
    sw_sleep = 1; cyc(3); sw_sleep = 0; cyc(30);
    chk(!busy, "R8 later wake", busy, 0);
    // R8 ext released during ramp-down
    ext_sleep = 1; cyc(5); ext_sleep = 0; cyc(30);
    chk(sleep_mode, "R8 ext early fall ignored", sleep_mode, 1);
    ext_sleep = 1; cyc(5); ext_sleep = 0; cyc(30);
    chk(!busy, "R8 ext later wake", busy, 0);
    // R11 timeout
    hold_sense = 1; sw_sleep = 1; cyc(TMO + 4);
    chk(ramp_err && busy, "R11 timeout sets", ramp_err, 1);
    hold_sense = 0; cyc(30);
    chk(sleep_mode && ramp_err, "R11 sticky and advance", ramp_err, 1);
    sw_sleep = 0; cyc(30);
    chk(!busy && ramp_err, "R11 still set after wake", ramp_err, 1);
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule